// File: doc/BRIEF.md
# Extended-State Restore Header Checker

This unit decides the outcome of a processor's extended-state restore operation before any state data moves. A start pulse presents the requested-feature mask (two 64-bit request registers), the enabled-feature register, the operand address, the CPU capability flags, the OS control bits and the instruction prefixes. If none of the checks that do not need memory fails, the unit collects the 64-byte save-area header as eight 64-bit beats and then one beat that carries the saved control/status word. It then pulses `done` with a fault code. When there is no fault, it also gives a per-component action vector for components 0 to 2 and a flag that says whether the control/status word is loaded from memory.

The beat input uses valid/ready. `beat_ready` is high only while the unit is collecting. A beat transfers on a clock edge where both `beat_valid` and `beat_ready` are high. The source may hold `beat_valid` low for any number of cycles, and the unit waits. The unit never drops `beat_ready` in the middle of an operation, so back-pressure comes only from the source side. Control and result pins are plain levels or pulses.

Top module: `restore_hdr_check`

## Requirements
- R1: The effective mask is `en_mask & {req_hi[31:0], req_lo[31:0]}`. Bits 63:32 of both request inputs have no effect on any output.
- R2: While idle, a start with `has_xs` clear, `os_enable` clear, or any bit of `pfx` set gives `done` one cycle later with fault code 1 (invalid opcode). No beat is taken.
- R3: If R2 does not apply and `task_sw` is set, the start gives `done` one cycle later with fault code 2 (device not available). No beat is taken.
- R4: If R2 and R3 do not apply and address bits 5:0 are not all zero, the start gives `done` one cycle later with fault code 3 (general protection). No beat is taken.
- R5: Otherwise `beat_ready` rises in the cycle after the start and stays high for exactly nine transfers: header beats 0..7 (beat k holds header bytes 8k+7..8k), then the status-word beat (bits 31:0). `done` pulses in the cycle after the ninth transfer, and `beat_ready` is low while `done` is high.
- R6: Bit 63 of header beat 1 selects the form: 0 is standard and 1 is compacted. The compacted form with `has_cmp` clear gives fault 3.
- R7: In the standard form, fault 3 is raised if beat 0 has a bit set where `en_mask` is clear, or if beat 1 or beat 2 is non-zero.
- R8: In the compacted form, fault 3 is raised if beat 1 bits 62:0 have a bit set where `en_mask` is clear, if beat 0 has a bit set where beat 1 is clear, or if any of beats 2..7 is non-zero.
- R9: Without a fault, `act[2i+1:2i]` for component i is 00 (keep) when mask bit i is clear. When mask bit i is set, the code is 01 (load) if beat 0 bit i is 1 and 10 (initialize) if it is 0.
- R10: Without a fault, `csw_load` is set in the standard form when mask bit 1 or mask bit 2 is set. In the compacted form it is set only when mask bit 1 and beat 0 bit 1 are both set.
- R11: When the status word would be loaded, any set bit among its reserved bits 31:16 gives fault 3. When it is not loaded, those bits have no effect.
- R12: A start while `beat_ready` is high has no effect on the operation in progress.
- R13: Fault code 0 means no fault. On any fault, `act` is zero and `csw_load` is clear. After reset, `done`, `fault`, `act` and `csw_load` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| req_lo | input | 64 | Request register supplying mask bits 31:0 |
| req_hi | input | 64 | Request register supplying mask bits 63:32 |
| en_mask | input | 64 | Enabled-feature register |
| op_addr | input | 64 | Save-area operand address |
| has_xs | input | 1 | Extended-state save/restore supported |
| has_cmp | input | 1 | Compacted form supported |
| os_enable | input | 1 | OS has enabled extended-state instructions |
| task_sw | input | 1 | Task-switched control bit |
| pfx | input | 4 | Forbidden prefixes seen (lock, operand-size, two repeat forms) |
| beat_valid | input | 1 | Beat source has data |
| beat_ready | output | 1 | Unit accepts a beat |
| beat_data | input | 64 | Header beat or status word |
| done | output | 1 | One-cycle result pulse |
| fault | output | 2 | 0 none, 1 invalid opcode, 2 device not available, 3 general protection |
| act | output | 6 | Two-bit action per component |
| csw_load | output | 1 | Status word is loaded from memory |

## Verification
On every cycle, the assertions check the fault order for early faults (invalid opcode, then device not available, then misalignment), that `beat_ready` is low while `done` is high, that a stall keeps the unit busy, and that a faulting result has no actions and no status-word load. Only the bench scenarios can show the header rules of each form, the standard-form status-word rule against the compacted one, the reserved-bit check being active only when the word is loaded, that the upper request halves are ignored, and that a start during collection is ignored. A behavioural reference model predicts `beat_ready`, `done` and the results on every clock.

// File: rtl/rhc_pkg.sv
package rhc_pkg;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_UD = 2'd1, FLT_NM = 2'd2, FLT_GP = 2'd3} flt_e;
  typedef enum logic [1:0] {ACT_KEEP = 2'd0, ACT_LOAD = 2'd1, ACT_INIT = 2'd2} act_e;
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_HDR = 2'd1, S_CSW = 2'd2} st_e;
endpackage

// File: rtl/rhc_precheck.sv
module rhc_precheck #(
  parameter int ALIGN_LOG2 = 6
) (
  input  logic                  has_xs,
  input  logic                  os_enable,
  input  logic                  task_sw,
  input  logic [3:0]            pfx,
  input  logic [ALIGN_LOG2-1:0] addr_lo,
  output rhc_pkg::flt_e         code
);
  import rhc_pkg::*;
  always_comb begin
    if (!has_xs || !os_enable || (|pfx)) code = FLT_UD;
    else if (task_sw)                    code = FLT_NM;
    else if (|addr_lo)                   code = FLT_GP;
    else                                 code = FLT_NONE;
  end
endmodule

// File: rtl/rhc_hdr_acc.sv
module rhc_hdr_acc #(
  parameter int BEAT_W    = 64,
  parameter int HDR_BEATS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              fire,
  input  logic [BEAT_W-1:0] data,
  output logic [BEAT_W-1:0] rst_q,
  output logic [BEAT_W-1:0] cmp_q,
  output logic              nz_b2,
  output logic              nz_hi,
  output logic              hdr_last
);
  localparam int CNT_W = $clog2(HDR_BEATS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HDR_BEATS - 1);
  logic [CNT_W-1:0] cnt;

  assign hdr_last = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt   <= '0;
      rst_q <= '0;
      cmp_q <= '0;
      nz_b2 <= 1'b0;
      nz_hi <= 1'b0;
    end else if (fire) begin
      cnt <= cnt + 1'b1;
      case (cnt)
        CNT_W'(0): rst_q <= data;
        CNT_W'(1): cmp_q <= data;
        CNT_W'(2): nz_b2 <= |data;
        default:   nz_hi <= nz_hi | (|data);
      endcase
    end
  end
endmodule

// File: rtl/rhc_resolve.sv
module rhc_resolve #(
  parameter int          MASK_W  = 64,
  parameter int          NCOMP   = 3,
  parameter int          CSW_W   = 32,
  parameter logic [31:0] CSW_RSV = 32'hFFFF_0000
) (
  input  logic [MASK_W-1:0]  mask,
  input  logic [MASK_W-1:0]  en,
  input  logic [MASK_W-1:0]  rstm,
  input  logic [MASK_W-1:0]  cmpf,
  input  logic               nz_b2,
  input  logic               nz_hi,
  input  logic               cmp_ok,
  input  logic [CSW_W-1:0]   csw,
  output rhc_pkg::flt_e      code,
  output logic [2*NCOMP-1:0] act,
  output logic               csw_ld
);
  import rhc_pkg::*;
  logic compacted, form_bad, ld_raw, rsv_bad;

  assign compacted = cmpf[MASK_W-1];

  always_comb begin
    if (compacted)
      form_bad = !cmp_ok
               || (|(cmpf[MASK_W-2:0] & ~en[MASK_W-2:0]))
               || (|(rstm & ~cmpf))
               || nz_b2 || nz_hi;
    else
      form_bad = (|(rstm & ~en)) || (|cmpf) || nz_b2;
    ld_raw  = compacted ? (mask[1] && rstm[1]) : (mask[1] || mask[2]);
    rsv_bad = ld_raw && (|(csw & CSW_RSV[CSW_W-1:0]));
  end

  assign code   = (form_bad || rsv_bad) ? FLT_GP : FLT_NONE;
  assign csw_ld = ld_raw && (code == FLT_NONE);

  for (genvar i = 0; i < NCOMP; i++) begin : g_comp
    always_comb begin
      if (code != FLT_NONE || !mask[i]) act[2*i +: 2] = ACT_KEEP;
      else if (rstm[i])                 act[2*i +: 2] = ACT_LOAD;
      else                              act[2*i +: 2] = ACT_INIT;
    end
  end
endmodule

// File: rtl/restore_hdr_check.sv
module restore_hdr_check #(
  parameter int          HALF_W     = 32,
  parameter int          ADDR_W     = 64,
  parameter int          ALIGN_LOG2 = 6,
  parameter int          HDR_BEATS  = 8,
  parameter int          NCOMP      = 3,
  parameter int          CSW_W      = 32,
  parameter logic [31:0] CSW_RSV    = 32'hFFFF_0000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [2*HALF_W-1:0]   req_lo,
  input  logic [2*HALF_W-1:0]   req_hi,
  input  logic [2*HALF_W-1:0]   en_mask,
  input  logic [ADDR_W-1:0]     op_addr,
  input  logic                  has_xs,
  input  logic                  has_cmp,
  input  logic                  os_enable,
  input  logic                  task_sw,
  input  logic [3:0]            pfx,
  input  logic                  beat_valid,
  output logic                  beat_ready,
  input  logic [2*HALF_W-1:0]   beat_data,
  output logic                  done,
  output logic [1:0]            fault,
  output logic [2*NCOMP-1:0]    act,
  output logic                  csw_load
);
  import rhc_pkg::*;
  localparam int MASK_W = 2 * HALF_W;

  st_e               state;
  logic [MASK_W-1:0] mask_q, en_q, rst_q, cmp_q;
  logic              cmp_ok_q, nz_b2, nz_hi, hdr_last, fire, take;
  flt_e              pre_code, fin_code;
  logic [2*NCOMP-1:0] fin_act;
  logic              fin_ld;
  logic              unused_bits;

  assign unused_bits = ^{req_lo[MASK_W-1:HALF_W], req_hi[MASK_W-1:HALF_W],
                         op_addr[ADDR_W-1:ALIGN_LOG2], beat_data[MASK_W-1:CSW_W]};

  assign beat_ready = (state != S_IDLE);
  assign fire       = beat_valid && beat_ready;
  assign take       = start && (state == S_IDLE);

  rhc_precheck #(.ALIGN_LOG2(ALIGN_LOG2)) u_pre (
    .has_xs(has_xs), .os_enable(os_enable), .task_sw(task_sw), .pfx(pfx),
    .addr_lo(op_addr[ALIGN_LOG2-1:0]), .code(pre_code)
  );

  rhc_hdr_acc #(.BEAT_W(MASK_W), .HDR_BEATS(HDR_BEATS)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(take), .fire(fire && state == S_HDR),
    .data(beat_data), .rst_q(rst_q), .cmp_q(cmp_q), .nz_b2(nz_b2),
    .nz_hi(nz_hi), .hdr_last(hdr_last)
  );

  rhc_resolve #(.MASK_W(MASK_W), .NCOMP(NCOMP), .CSW_W(CSW_W), .CSW_RSV(CSW_RSV)) u_res (
    .mask(mask_q), .en(en_q), .rstm(rst_q), .cmpf(cmp_q), .nz_b2(nz_b2),
    .nz_hi(nz_hi), .cmp_ok(cmp_ok_q), .csw(beat_data[CSW_W-1:0]),
    .code(fin_code), .act(fin_act), .csw_ld(fin_ld)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      done     <= 1'b0;
      fault    <= FLT_NONE;
      act      <= '0;
      csw_load <= 1'b0;
      mask_q   <= '0;
      en_q     <= '0;
      cmp_ok_q <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          mask_q   <= en_mask & {req_hi[HALF_W-1:0], req_lo[HALF_W-1:0]};
          en_q     <= en_mask;
          cmp_ok_q <= has_cmp;
          if (pre_code != FLT_NONE) begin
            done     <= 1'b1;
            fault    <= pre_code;
            act      <= '0;
            csw_load <= 1'b0;
          end else begin
            state <= S_HDR;
          end
        end
        S_HDR: if (fire && hdr_last) state <= S_CSW;
        S_CSW: if (fire) begin
          done     <= 1'b1;
          fault    <= fin_code;
          act      <= fin_act;
          csw_load <= fin_ld;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rhc_checker.sv
module rhc_checker #(
  parameter int ALIGN_LOG2 = 6,
  parameter int NCOMP      = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic                  has_xs,
  input logic                  os_enable,
  input logic                  task_sw,
  input logic [3:0]            pfx,
  input logic [ALIGN_LOG2-1:0] addr_lo,
  input logic                  beat_valid,
  input logic                  beat_ready,
  input logic                  done,
  input logic [1:0]            fault,
  input logic [2*NCOMP-1:0]    act,
  input logic                  csw_load
);
  logic ud_cond, bad_code;
  assign ud_cond = !has_xs || !os_enable || (pfx != 4'd0);

  always_comb begin
    bad_code = 1'b0;
    for (int i = 0; i < NCOMP; i++)
      if (act[2*i +: 2] == 2'b11) bad_code = 1'b1;
  end

  p_ud_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !beat_ready && ud_cond) |=> (done && fault == 2'd1));
  p_nm_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !beat_ready && !ud_cond && task_sw) |=> (done && fault == 2'd2));
  p_misalign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !beat_ready && !ud_cond && !task_sw && addr_lo != '0) |=> (done && fault == 2'd3));
  p_idle_at_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !beat_ready);
  p_action_codes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bad_code);
  p_stall_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ready && !beat_valid) |=> beat_ready);
  p_fault_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault != 2'd0) |-> (act == '0 && !csw_load));
endmodule

bind restore_hdr_check rhc_checker #(.ALIGN_LOG2(ALIGN_LOG2), .NCOMP(NCOMP)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .has_xs(has_xs), .os_enable(os_enable),
  .task_sw(task_sw), .pfx(pfx), .addr_lo(op_addr[ALIGN_LOG2-1:0]),
  .beat_valid(beat_valid), .beat_ready(beat_ready), .done(done), .fault(fault),
  .act(act), .csw_load(csw_load)
);

// File: tb/restore_hdr_check_test.sv
module restore_hdr_check_test;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [63:0] req_lo = '0, req_hi = '0, en_mask = '0, op_addr = '0, beat_data = '0;
  logic        has_xs = 1'b0, has_cmp = 1'b0, os_enable = 1'b0, task_sw = 1'b0;
  logic [3:0]  pfx = '0;
  logic        beat_valid = 1'b0, beat_ready, done, csw_load;
  logic [1:0]  fault;
  logic [5:0]  act;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  string cur_req = "R13";
  logic [63:0] hb [0:8];

  // behavioural reference state
  bit          m_busy = 0, m_done = 0, m_cm = 0, m_ld = 0;
  int          m_cnt = 0;
  logic [63:0] m_mask = '0, m_en = '0;
  logic [63:0] hq [$];
  logic [1:0]  m_fault = '0;
  logic [5:0]  m_act = '0;

  always #5 clk = ~clk;

  restore_hdr_check uut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_lo(req_lo), .req_hi(req_hi),
    .en_mask(en_mask), .op_addr(op_addr), .has_xs(has_xs), .has_cmp(has_cmp),
    .os_enable(os_enable), .task_sw(task_sw), .pfx(pfx), .beat_valid(beat_valid),
    .beat_ready(beat_ready), .beat_data(beat_data), .done(done), .fault(fault),
    .act(act), .csw_load(csw_load)
  );

  task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, got, exp);
    end
  endtask

  task automatic finish_up();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic void evaluate(input logic [63:0] csw);
    bit comp, bad;
    comp = hq[1][63];
    bad  = 0;
    if (comp) begin
      if (!m_cm) bad = 1;
      for (int i = 0; i < 63; i++) if (hq[1][i] && !m_en[i]) bad = 1;
      for (int i = 0; i < 64; i++) if (hq[0][i] && !hq[1][i]) bad = 1;
      for (int k = 2; k < 8; k++) if (hq[k] != 0) bad = 1;
      m_ld = m_mask[1] && hq[0][1];
    end else begin
      for (int i = 0; i < 64; i++) if (hq[0][i] && !m_en[i]) bad = 1;
      if (hq[1] != 0 || hq[2] != 0) bad = 1;
      m_ld = m_mask[1] || m_mask[2];
    end
    if (m_ld && (csw[31:16] != 0)) bad = 1;
    m_act = '0;
    if (bad) begin
      m_fault = 2'd3;
      m_ld    = 0;
    end else begin
      m_fault = 2'd0;
      for (int i = 0; i < 3; i++)
        if (m_mask[i]) m_act[2*i +: 2] = hq[0][i] ? 2'b01 : 2'b10;
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_fault = 0; m_act = 0; m_ld = 0;
    end else begin
      m_done = 0;
      if (!m_busy && start) begin
        m_mask = en_mask & {req_hi[31:0], req_lo[31:0]};
        m_en   = en_mask;
        m_cm   = has_cmp;
        if (!has_xs || !os_enable || pfx != 0) begin m_done = 1; m_fault = 1; end
        else if (task_sw)                      begin m_done = 1; m_fault = 2; end
        else if (op_addr[5:0] != 0)            begin m_done = 1; m_fault = 3; end
        else begin m_busy = 1; m_cnt = 0; hq.delete(); end
        if (m_done) begin m_act = 0; m_ld = 0; end
      end else if (m_busy && beat_valid) begin
        if (m_cnt < 8) begin hq.push_back(beat_data); m_cnt++; end
        else begin evaluate(beat_data); m_busy = 0; m_done = 1; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("beat_ready", beat_ready, m_busy);
      chk("done", done, m_done);
      if (m_done) begin
        chk("fault", fault, m_fault);
        chk("act", act, m_act);
        chk("csw_load", csw_load, m_ld);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_up();
    end
  end

  task automatic set_hdr(input logic [63:0] rs, input logic [63:0] cm, input logic [63:0] csw);
    for (int i = 0; i < 9; i++) hb[i] = '0;
    hb[0] = rs; hb[1] = cm; hb[8] = csw;
  endtask

  task automatic op(input string rq, input logic [63:0] rl, input logic [63:0] rh,
                    input logic [63:0] en, input logic [63:0] ad, input logic xs,
                    input logic cm, input logic os, input logic ts, input logic [3:0] pf,
                    input bit gap);
    @(posedge clk); #1;
    cur_req = rq;
    req_lo = rl; req_hi = rh; en_mask = en; op_addr = ad;
    has_xs = xs; has_cmp = cm; os_enable = os; task_sw = ts; pfx = pf;
    start = 1;
    @(posedge clk); #1;
    start = 0;
    if (beat_ready) begin
      for (int i = 0; i < 9; i++) begin
        if (gap && i == 3) begin
          beat_valid = 0;
          start = 1;   // ignored while collecting (R12)
          req_lo = 64'h0; en_mask = 64'h0;
          @(posedge clk); #1;
          start = 0;
          @(posedge clk); #1;
        end
        beat_valid = 1;
        beat_data  = hb[i];
        @(posedge clk); #1;
      end
      beat_valid = 0;
      beat_data  = '0;
    end
    @(posedge clk); #1;
  endtask

  localparam logic [63:0] CF = 64'h8000_0000_0000_0000;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    cur_req = "R13";
    chk("reset done", done, 0);
    chk("reset fault", fault, 0);
    chk("reset act", act, 0);
    chk("reset csw_load", csw_load, 0);
    @(posedge clk); #1; rst_n = 1;

    // standard form, mixed load/init
    set_hdr(64'h5, 64'h0, 64'h1F80);
    op("R9", 64'h7, 64'h0, 64'h7, 64'h1000, 1, 0, 1, 0, 4'h0, 0);
    // standard, only component 2 requested: status word still loaded
    set_hdr(64'h4, 64'h0, 64'h1F80);
    op("R10", 64'h4, 64'h0, 64'h7, 64'h2000, 1, 0, 1, 0, 4'h0, 0);
    // compacted form
    set_hdr(64'h3, CF | 64'h7, 64'h1F80);
    op("R9", 64'h7, 64'h0, 64'h7, 64'h40, 1, 1, 1, 0, 4'h0, 0);
    set_hdr(64'h4, CF | 64'h7, 64'h1F80);
    op("R10", 64'h4, 64'h0, 64'h7, 64'h40, 1, 1, 1, 0, 4'h0, 0);
    // upper request halves ignored
    set_hdr(64'h1, 64'h0, 64'h0);
    op("R1", 64'hFFFF_FFFF_0000_0001, 64'hFFFF_FFFF_0000_0000, 64'h7, 64'h0, 1, 0, 1, 0, 4'h0, 0);
    // early faults and their order
    op("R2", 64'h7, 64'h0, 64'h7, 64'h0, 1, 0, 1, 1, 4'h1, 0);
    op("R2", 64'h7, 64'h0, 64'h7, 64'h0, 1, 0, 0, 0, 4'h0, 0);
    op("R2", 64'h7, 64'h0, 64'h7, 64'h0, 0, 0, 1, 0, 4'h0, 0);
    op("R3", 64'h7, 64'h0, 64'h7, 64'h8, 1, 0, 1, 1, 4'h0, 0);
    op("R4", 64'h7, 64'h0, 64'h7, 64'h1008, 1, 0, 1, 0, 4'h0, 0);
    // form selection without compacted support
    set_hdr(64'h1, CF | 64'h1, 64'h0);
    op("R6", 64'h7, 64'h0, 64'h7, 64'h0, 1, 0, 1, 0, 4'h0, 0);
    // standard-form header rules
    set_hdr(64'h9, 64'h0, 64'h0);
    op("R7", 64'h7, 64'h0, 64'h7, 64'h0, 1, 0, 1, 0, 4'h0, 0);
    set_hdr(64'h1, 64'h0, 64'h0); hb[2] = 64'h100;
    op("R7", 64'h7, 64'h0, 64'h7, 64'h0, 1, 0, 1, 0, 4'h0, 0);
    set_hdr(64'h1, 64'h0, 64'h0); hb[5] = 64'h1;
    op("R7", 64'h7, 64'h0, 64'h7, 64'h0, 1, 0, 1, 0, 4'h0, 0);
    // compacted-form header rules
    set_hdr(64'h1, CF | 64'hF, 64'h0);
    op("R8", 64'h7, 64'h0, 64'h7, 64'h0, 1, 1, 1, 0, 4'h0, 0);
    set_hdr(64'h5, CF | 64'h1, 64'h0);
    op("R8", 64'h7, 64'h0, 64'h7, 64'h0, 1, 1, 1, 0, 4'h0, 0);
    set_hdr(64'h1, CF | 64'h1, 64'h0); hb[6] = 64'h2;
    op("R8", 64'h7, 64'h0, 64'h7, 64'h0, 1, 1, 1, 0, 4'h0, 0);
    // reserved status-word bits
    set_hdr(64'h3, 64'h0, 64'h0001_1F80);
    op("R11", 64'h3, 64'h0, 64'h7, 64'h0, 1, 0, 1, 0, 4'h0, 0);
    set_hdr(64'h1, 64'h0, 64'hFFFF_0000);
    op("R11", 64'h1, 64'h0, 64'h7, 64'h0, 1, 0, 1, 0, 4'h0, 0);
    // stall and start while busy
    set_hdr(64'h6, 64'h0, 64'h1F80);
    op("R12", 64'h7, 64'h0, 64'h7, 64'h0, 1, 0, 1, 0, 4'h0, 1);
    set_hdr(64'h2, CF | 64'h3, 64'h1F80);
    op("R5", 64'h3, 64'h0, 64'h3, 64'h0, 1, 1, 1, 0, 4'h0, 1);
    repeat (3) @(posedge clk);
    finish_up();
  end
endmodule